// File: doc/BRIEF.md
# Serial NOR Flash Single-Byte Operation Sequencer

This block runs one single-byte operation on a serial NOR flash device through a mode-0 SPI master and an active-low chip select. A client presents an operation (read, program or sector erase), a 24-bit address and a write byte with a one-cycle request. The block then clocks out every frame that the operation needs, with no further help from the client. When the operation ends it raises `done` for one cycle. For a read, the received byte is on `rdata`.

Each command travels in a chip-select frame of its own. A program or an erase has four kinds of frame, in this order. A write-enable frame comes first. The command frame follows. Then come status-register polls, repeated until the device reports ready. A write-disable frame closes the operation. Completion is taken from the polled ready bit, not from a fixed wait. If the device never reports ready, a bounded poll count stops the operation with an error flag.

Top module: `nor_flash_seq`

## Requirements
- R1: Operation code 2'b00 (and the unused code 2'b11) is a read. It sends one frame of five bytes: 0x03, the address bytes from most to least significant, then 0xFF. `rdata` returns the byte received during the 0xFF slot.
- R2: Operation code 2'b01 is a program. It sends a one-byte frame 0x06, then a five-byte frame of 0x02, the three address bytes (most significant first) and the write byte.
- R3: Operation code 2'b10 is a sector erase. It sends a one-byte frame 0x06, then a four-byte frame of 0x20 and the three address bytes (most significant first).
- R4: After the command frame of a program or erase, the block repeats a two-byte frame 0x70, 0xFF. It stops once bit 7 of the byte received in the second slot is 1. It then sends a one-byte frame 0x04 and finishes.
- R5: If POLL_MAX status frames in a row report not ready, the block finishes with `err` = 1 and sends no 0x04 frame. `err` holds until the next accepted request clears it.
- R6: Chip select rises only after the last bit of a frame's last byte has fully shifted. Every frame therefore holds a whole number of bytes. SCLK is low while chip select is high. MOSI is stable at each rising SCLK edge, where MISO is sampled.
- R7: Between two frames, chip select stays high for at least GAP_SCLK SCLK periods (2·CLK_DIV·GAP_SCLK clock cycles).
- R8: A request is taken only while `busy` is 0. A request raised while busy starts no frame and does not change the running operation.
- R9: `busy` is 1 from the cycle after acceptance until `done`. `done` is a one-cycle pulse, with `busy` = 0 in the same cycle.
- R10: After reset, chip select is high, SCLK is low, and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 read |
| req_addr | input | 8·ADDR_BYTES | Byte address |
| req_wdata | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status polling timed out |
| rdata | output | 8 | Byte returned by the last read |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench attacks these hazards:
- A flash model that stays busy for zero to three polls, which catches a sequencer that stops after the first status frame or never samples the ready bit. A design that read the wrong bit would poll until it timed out.
- A device that never becomes ready, which shows whether the block gives up after exactly POLL_MAX polls, flags `err`, and clears the flag on the next request.
- A request raised in the middle of an operation, which must not splice a second command into the traffic.
- A chip-select monitor that flags any frame ending mid-byte and any inter-frame gap shorter than the minimum. Releasing chip select one edge early, or shortening the gap counter, is reported there.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_ALT   = 2'b11
   } nfs_op_e;

   typedef enum logic [1:0] {
      FR_WEN,
      FR_CMD,
      FR_POLL,
      FR_WDIS
   } nfs_frame_e;

   localparam logic [7:0] OPC_WEN   = 8'h06;
   localparam logic [7:0] OPC_WDIS  = 8'h04;
   localparam logic [7:0] OPC_PROG  = 8'h02;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_ERASE = 8'h20;
   localparam logic [7:0] OPC_FSR   = 8'h70;
   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam int         RDY_BIT   = 7;

endpackage

// File: rtl/nfs_byte_shifter.sv
module nfs_byte_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] tx_i,
   output logic       busy_o,
   output logic       done_o,
   output logic [7:0] rx_o,
   output logic       sclk_o,
   output logic       mosi_o,
   input  logic       miso_i
);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("nfs_byte_shifter: CLK_DIV must be at least 1");
   end

   logic       tick;
   logic       active_q, phase_q, done_q, sclk_q;
   logic [2:0] bit_q;
   logic [7:0] sh_q, rx_q;

   // half-period timer: none needed when each half is one cycle
   if (CLK_DIV == 1) begin : g_fast
      assign tick = 1'b1;
   end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] div_q;
      assign tick = (div_q == CW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 div_q <= '0;
         else if (start_i || !active_q || tick) div_q <= '0;
         else                        div_q <= div_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         done_q   <= 1'b0;
         sclk_q   <= 1'b0;
         bit_q    <= '0;
         sh_q     <= '0;
         rx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            active_q <= 1'b1;
            sh_q     <= tx_i;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
         end else if (active_q && tick) begin
            if (!phase_q) begin
               sclk_q  <= 1'b1;
               phase_q <= 1'b1;
               rx_q    <= {rx_q[6:0], miso_i};
            end else begin
               sclk_q  <= 1'b0;
               phase_q <= 1'b0;
               sh_q    <= {sh_q[6:0], 1'b0};
               bit_q   <= bit_q + 1'b1;
               if (bit_q == 3'd7) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end
            end
         end
      end
   end

   assign busy_o = active_q;
   assign done_o = done_q;
   assign rx_o   = rx_q;
   assign sclk_o = sclk_q;
   assign mosi_o = sh_q[7];

   // R8: a byte is never started on top of one in flight
   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !active_q);
   // R6: SCLK rests low whenever no byte is shifting
   p_sclk_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !sclk_q);
   // R6: completion only after the falling edge of the eighth bit
   p_done_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!sclk_q && $past(active_q)));

endmodule

// File: rtl/nfs_byte_mux.sv
module nfs_byte_mux
   import nfs_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   localparam int AW = 8 * ADDR_BYTES,
   localparam int IW = $clog2(ADDR_BYTES + 2)
) (
   input  nfs_frame_e    frame_i,
   input  logic [IW-1:0] idx_i,
   input  nfs_op_e       op_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    wdata_i,
   output logic [7:0]    byte_o,
   output logic          last_o
);

   logic [IW-1:0] len_m1;
   logic [7:0]    opc;

   always_comb begin
      unique case (op_i)
         OP_PROG:  opc = OPC_PROG;
         OP_ERASE: opc = OPC_ERASE;
         default:  opc = OPC_READ;
      endcase
   end

   always_comb begin
      byte_o = FILL_BYTE;
      len_m1 = '0;
      unique case (frame_i)
         FR_WEN:  byte_o = OPC_WEN;
         FR_WDIS: byte_o = OPC_WDIS;
         FR_POLL: begin
            len_m1 = IW'(1);
            if (idx_i == '0) byte_o = OPC_FSR;
         end
         default: begin
            len_m1 = (op_i == OP_ERASE) ? IW'(ADDR_BYTES) : IW'(ADDR_BYTES + 1);
            if (idx_i == '0) byte_o = opc;
            for (int k = 1; k <= ADDR_BYTES; k++) begin
               if (idx_i == IW'(k)) byte_o = addr_i[8*(ADDR_BYTES-k) +: 8];
            end
            if (idx_i == IW'(ADDR_BYTES + 1) && op_i == OP_PROG) byte_o = wdata_i;
         end
      endcase
      last_o = (idx_i == len_m1);
   end

endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
   import nfs_pkg::*;
#(
   parameter int CLK_DIV    = 2,
   parameter int GAP_SCLK   = 2,
   parameter int POLL_MAX   = 4096,
   parameter int ADDR_BYTES = 3,
   localparam int AW = 8 * ADDR_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [7:0]    rdata,
   output logic          spi_sclk,
   output logic          spi_cs_n,
   output logic          spi_mosi,
   input  logic          spi_miso
);

   localparam int IW      = $clog2(ADDR_BYTES + 2);
   localparam int GAP_CYC = 2 * CLK_DIV * GAP_SCLK;
   localparam int GW      = $clog2(GAP_CYC);
   localparam int PW      = $clog2(POLL_MAX + 1);

   if (GAP_SCLK < 2) begin : g_bad_gap
      $error("nor_flash_seq: GAP_SCLK must be at least 2");
   end
   if (POLL_MAX < 1) begin : g_bad_poll
      $error("nor_flash_seq: POLL_MAX must be at least 1");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("nor_flash_seq: ADDR_BYTES must lie in 1..4");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} st_e;

   st_e           state_q;
   nfs_frame_e    frame_q;
   nfs_op_e       op_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    wdata_q, rdata_q;
   logic [PW-1:0] poll_q;
   logic [GW-1:0] gap_q;
   logic          rdy_q, done_q, err_q, cs_n_q;

   logic       sh_start, sh_busy, sh_done;
   logic [7:0] sh_rx, tx_byte;
   logic       byte_last, is_read;

   assign sh_start = (state_q == ST_LOAD);
   assign is_read  = (op_q != OP_PROG) && (op_q != OP_ERASE);

   nfs_byte_mux #(.ADDR_BYTES(ADDR_BYTES)) u_mux (
      .frame_i (frame_q),
      .idx_i   (idx_q),
      .op_i    (op_q),
      .addr_i  (addr_q),
      .wdata_i (wdata_q),
      .byte_o  (tx_byte),
      .last_o  (byte_last)
   );

   nfs_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sh_start),
      .tx_i    (tx_byte),
      .busy_o  (sh_busy),
      .done_o  (sh_done),
      .rx_o    (sh_rx),
      .sclk_o  (spi_sclk),
      .mosi_o  (spi_mosi),
      .miso_i  (spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         frame_q <= FR_CMD;
         op_q    <= OP_READ;
         idx_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         poll_q  <= '0;
         gap_q   <= '0;
         rdy_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               op_q    <= nfs_op_e'(req_op);
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               err_q   <= 1'b0;
               idx_q   <= '0;
               frame_q <= (req_op == OP_PROG || req_op == OP_ERASE) ? FR_WEN : FR_CMD;
               state_q <= ST_LOAD;
            end
            ST_LOAD: begin
               cs_n_q  <= 1'b0;
               state_q <= ST_SHIFT;
            end
            ST_SHIFT: if (sh_done) begin
               if (frame_q == FR_POLL && idx_q == IW'(1)) rdy_q <= sh_rx[RDY_BIT];
               if (frame_q == FR_CMD && byte_last && is_read) rdata_q <= sh_rx;
               if (byte_last) begin
                  cs_n_q  <= 1'b1;
                  gap_q   <= '0;
                  state_q <= ST_GAP;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_LOAD;
               end
            end
            default: begin
               if (gap_q != GW'(GAP_CYC - 1)) begin
                  gap_q <= gap_q + 1'b1;
               end else begin
                  idx_q   <= '0;
                  state_q <= ST_LOAD;
                  unique case (frame_q)
                     FR_WEN: frame_q <= FR_CMD;
                     FR_CMD: begin
                        if (is_read) begin
                           done_q  <= 1'b1;
                           state_q <= ST_IDLE;
                        end else begin
                           frame_q <= FR_POLL;
                           poll_q  <= '0;
                        end
                     end
                     FR_POLL: begin
                        if (rdy_q) begin
                           frame_q <= FR_WDIS;
                        end else if (poll_q == PW'(POLL_MAX - 1)) begin
                           err_q   <= 1'b1;
                           done_q  <= 1'b1;
                           state_q <= ST_IDLE;
                        end else begin
                           poll_q <= poll_q + 1'b1;
                        end
                     end
                     default: begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign rdata    = rdata_q;
   assign spi_cs_n = cs_n_q;

   // R6: chip select stays low for as long as a byte is shifting
   p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !spi_cs_n);
   // R6: chip select rises only right after a completed byte
   p_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> $past(sh_done));
   // R6: clock rests low with the device deselected
   p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);
   // R7: deselected throughout the inter-frame gap
   p_gap_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> spi_cs_n);
   // R5: the poll count never passes its limit
   p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q < PW'(POLL_MAX));
   // R5: error is only raised together with completion
   p_err_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
   // R9: completion is a single-cycle pulse seen with busy low
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/nor_flash_seq_bench.sv
module nor_flash_seq_bench;
   import nfs_pkg::*;

   localparam int DIV   = 2;
   localparam int GAPS  = 2;
   localparam int POLLS = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        busy, done, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic [7:0]  rdata;

   always #10 clk = ~clk;

   nor_flash_seq #(.CLK_DIV(DIV), .GAP_SCLK(GAPS), .POLL_MAX(POLLS), .ADDR_BYTES(3)) u_nor_flash_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rdata(rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int unsigned n_chk = 0, n_bad = 0;
   longint cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc++;

   task automatic check(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- flash device model ----------------
   logic [7:0] mem [int];
   bit         wel = 0;
   int         busy_left = 0, busy_cfg = 0;
   int         bitcnt = 0, fr_n = 0, proto_bad = 0;
   logic [7:0] rx_sh = '0, tx_byte = 8'hFF;
   logic [7:0] fr_b [8];
   longint     cs_rise_cyc = -1000;
   logic       miso_r = 1'b1;
   bit [63:0]  got_dat [$];
   int         got_len [$];
   assign spi_miso = miso_r;

   function automatic logic [7:0] mem_rd(logic [23:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
   endfunction

   always @(negedge spi_cs_n) if (rst_n) begin
      if (cyc - cs_rise_cyc < 2*DIV*GAPS) proto_bad++;
      if (spi_sclk) proto_bad++;
      bitcnt = 0; fr_n = 0; tx_byte = 8'hFF; miso_r = 1'b1;
   end

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      rx_sh = {rx_sh[6:0], spi_mosi};
      bitcnt++;
      if (bitcnt % 8 == 0) begin
         if (fr_n < 8) fr_b[fr_n] = rx_sh;
         fr_n++;
         tx_byte = 8'hFF;
         if (fr_n == 1 && rx_sh == 8'h70) tx_byte = (busy_left > 0) ? 8'h00 : 8'h80;
         if (fr_n == 4 && fr_b[0] == 8'h03) tx_byte = mem_rd({fr_b[1], fr_b[2], fr_b[3]});
      end
   end

   always @(negedge spi_sclk) if (!spi_cs_n) miso_r = tx_byte[7 - (bitcnt % 8)];

   always @(posedge spi_cs_n) if (rst_n && fr_n > 0) begin
      bit [63:0] d;
      logic [23:0] a;
      int keys [$];
      cs_rise_cyc = cyc;
      if (bitcnt % 8 != 0) proto_bad++;
      d = '0;
      for (int k = 0; k < fr_n && k < 8; k++) d = {d[55:0], fr_b[k]};
      got_dat.push_back(d);
      got_len.push_back(fr_n);
      a = {fr_b[1], fr_b[2], fr_b[3]};
      case (fr_b[0])
         8'h06: if (fr_n == 1) wel = 1;
         8'h04: wel = 0;
         8'h02: if (wel && fr_n == 5) begin
            mem[int'(a)] = mem_rd(a) & fr_b[4];
            busy_left = busy_cfg; wel = 0;
         end
         8'h20: if (wel && fr_n == 4) begin
            foreach (mem[k]) if ((k >> 12) == (int'(a) >> 12)) keys.push_back(k);
            foreach (keys[i]) mem.delete(keys[i]);
            busy_left = busy_cfg; wel = 0;
         end
         8'h70: if (busy_left > 0) busy_left--;
         default: ;
      endcase
   end

   // ---------------- reference and expectations ----------------
   logic [7:0] ref_mem [int];
   bit [63:0]  exp_dat [$];
   int         exp_len [$];

   function automatic logic [7:0] ref_rd(logic [23:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'hFF;
   endfunction

   function automatic void push_fr(int n, bit [63:0] d);
      exp_len.push_back(n);
      exp_dat.push_back(d);
   endfunction

   function automatic void build_exp(logic [1:0] op, logic [23:0] a, logic [7:0] d, int k, bit tmo);
      int npoll;
      exp_len.delete(); exp_dat.delete();
      if (op == 2'b01 || op == 2'b10) begin
         push_fr(1, 64'h06);
         if (op == 2'b01) push_fr(5, {24'h0, 8'h02, a, d});
         else             push_fr(4, {32'h0, 8'h20, a});
         npoll = tmo ? POLLS : k + 1;
         for (int i = 0; i < npoll; i++) push_fr(2, 64'h70FF);
         if (!tmo) push_fr(1, 64'h04);
      end else begin
         push_fr(5, {24'h0, 8'h03, a, 8'hFF});
      end
   endfunction

   function automatic void ref_apply(logic [1:0] op, logic [23:0] a, logic [7:0] d);
      int keys [$];
      if (op == 2'b01) ref_mem[int'(a)] = ref_rd(a) & d;
      if (op == 2'b10) begin
         foreach (ref_mem[k]) if ((k >> 12) == (int'(a) >> 12)) keys.push_back(k);
         foreach (keys[i]) ref_mem.delete(keys[i]);
      end
   endfunction

   function automatic bit frames_match();
      if (got_len.size() != exp_len.size()) return 0;
      foreach (exp_len[i])
         if (got_len[i] != exp_len[i] || got_dat[i] != exp_dat[i]) return 0;
      return 1;
   endfunction

   function automatic string req_of(logic [1:0] op);
      return (op == 2'b01) ? "R2/R4" : (op == 2'b10) ? "R3/R4" : "R1";
   endfunction

   // one operation; intrude = pulse a second request while busy (R8)
   task automatic run_op(logic [1:0] op, logic [23:0] a, logic [7:0] d, int k, bit tmo, bit intrude);
      int wait_n;
      logic [7:0] r, exp_r;
      logic e;
      got_len.delete(); got_dat.delete();
      busy_cfg = k;
      proto_bad = 0;
      build_exp(op, a, d, k, tmo);
      exp_r = ref_rd(a);
      @(negedge clk);
      req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0;
      check(busy === 1'b1, "R9 busy after accept", busy, 1);
      if (intrude) begin
         repeat (5) @(negedge clk);
         req_valid = 1; req_op = 2'b00; req_addr = ~a;
         @(negedge clk);
         req_valid = 0;
      end
      wait_n = 0;
      while (done !== 1'b1 && wait_n < 20000) begin
         @(negedge clk);
         wait_n++;
      end
      check(done === 1'b1, "R9 done seen", done, 1);
      check(busy === 1'b0, "R9 busy low at done", busy, 0);
      r = rdata; e = err;
      @(negedge clk);
      check(done === 1'b0, "R9 done one cycle", done, 0);
      check(frames_match(), req_of(op), got_len.size(), exp_len.size());
      check(e === tmo, tmo ? "R5 err on timeout" : "R5 err clear", e, tmo);
      if (op == 2'b00 || op == 2'b11) check(r === exp_r, "R1 rdata", r, exp_r);
      ref_apply(op, a, d);
      if (intrude) begin
         int n0 = got_len.size();
         repeat (200) @(negedge clk);
         check(got_len.size() == n0 && spi_cs_n === 1'b1 && busy === 1'b0,
               "R8 request while busy ignored", got_len.size(), n0);
      end
      check(proto_bad == 0, "R6/R7 frame boundaries and gap", proto_bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(spi_cs_n === 1'b1, "R10 cs high", spi_cs_n, 1);
      check(spi_sclk === 1'b0, "R10 sclk low", spi_sclk, 0);
      check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10 flags low",
            {busy, done, err}, 0);

      // directed corners
      run_op(2'b01, 24'hA5C30F, 8'h3C, 0, 0, 0);   // ready on first poll
      run_op(2'b00, 24'hA5C30F, 8'h00, 0, 0, 0);   // read back
      run_op(2'b01, 24'hFFFFFF, 8'h81, 3, 0, 0);   // several busy polls
      run_op(2'b00, 24'hFFFFFF, 8'h00, 0, 0, 0);
      run_op(2'b10, 24'hA5C000, 8'h00, 2, 0, 0);   // erase sector
      run_op(2'b00, 24'hA5C30F, 8'h00, 0, 0, 0);   // erased reads 0xFF
      run_op(2'b11, 24'h000000, 8'h00, 0, 0, 0);   // alias read
      run_op(2'b10, 24'h010000, 8'h00, 1000, 1, 0); // device never ready
      busy_left = 0;
      run_op(2'b00, 24'h010000, 8'h00, 0, 0, 0);   // err cleared
      run_op(2'b01, 24'h123456, 8'h5A, 2, 0, 1);   // intruding request

      // constrained random
      for (int i = 0; i < 24; i++) begin
         logic [1:0]  op;
         logic [23:0] a;
         op = 2'($urandom % 3);
         a  = 24'h120000 | (24'($urandom % 2) << 12) | 24'($urandom % 4);
         run_op(op, a, 8'($urandom), int'($urandom % 4), 0, 0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule